// File: doc/BRIEF.md
# Audio Serial Port Control and Status Registers

This block is the software-facing register file of a stereo audio serial port. A host reaches it over a plain 32-bit word-addressed bus with a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. Command writes become enable and disable pulses and on/off levels for three units: the receiver, the clock generator and the transmitter. A mode word is held for the datapath. A status word collects ready, overrun and underrun events that the datapath reports. An interrupt mask gates those events onto a single level interrupt line.

Each unit is tracked by a two-state machine, `U_OFF` and `U_ON`:
- `U_OFF -> U_ON` is taken on an enable request with no disable request in the same write. It emits a one-cycle start pulse.
- `U_ON -> U_OFF` is taken on a disable request. It emits a one-cycle stop pulse.
- A software reset forces `U_OFF` from either state and emits no pulse.

Address decode selects one register per access, or none. It is an enumerated selection over the eleven mapped offsets.

The status flags are stored in one word:
- The clear alias drops the flags written as one.
- The set alias raises the flags written as one.
- Reading the receive holding register consumes the sample.
- Writing the transmit holding register marks the transmit slot as filled.

Top module: `aud_port_csr`

## Requirements
- R1: After reset the status, mode and interrupt mask read as zero, `irq` and all unit levels are low, and the version offset 0x28 returns the `VERSION` parameter.
- R2: A write to command offset 0x00 with bit 0 (receiver), bit 2 (clock) or bit 4 (transmitter) set turns that unit on. A unit turning on gives exactly one cycle of its start pulse. A unit turning off gives one cycle of its stop pulse, and bit 1, 3 or 5 turns the matching unit off. Enabling a unit that is already on gives no pulse. Status bit 0 mirrors the receiver level and status bit 4 mirrors the transmitter level.
- R3: When the enable and disable bits of one unit are written together, the unit ends off and no start pulse is given.
- R4: Offset 0x04 is a read/write mode word and is presented on `mode_cfg`.
- R5: Writing ones to offset 0x0C clears the matching status flags. Writing ones to offset 0x10 sets them. Only bits 1, 2, 5, 6, 15:8 and 27:20 are flags. Bits 0 and 4 are not changed by either alias.
- R6: Ones written to offset 0x14 set interrupt mask bits, and ones written to offset 0x18 clear them. The mask reads at offset 0x1C and keeps only bits 1, 2, 5 and 6. `irq` is high exactly when some flag among bits 1, 2, 5 and 6 is set together with its mask bit.
- R7: A receive push while the receiver is on stores the sample and sets status bit 1. Reading offset 0x20 returns the stored sample and clears bit 1.
- R8: A receive push while bit 1 is already set sets bit 2 and bit 8+channel, and the new sample replaces the old one.
- R9: Writing offset 0x24 presents the word on `tx_word` and clears status bit 5. A transmit pull while the transmitter is on sets bit 5.
- R10: A transmit pull while bit 5 is already set sets bit 6 and bit 20+channel.
- R11: Overrun and underrun flags stay set until cleared through offset 0x0C. An event in the same cycle as a clear of its flags leaves them set.
- R12: Receive pushes while the receiver is off and transmit pulls while the transmitter is off change no status bit and no holding register.
- R13: Command bit 7 returns every register except the version to zero and turns all units off without start or stop pulses, even when other command bits are also set. It gives one cycle of `dp_reset`.
- R14: Reads of offsets 0x00, 0x0C, 0x10, 0x14, 0x18 and 0x24 and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rx_push | input | 1 | Datapath delivers a received sample |
| rx_ch | input | 3 | Channel of the received sample |
| rx_data | input | 32 | Received sample |
| tx_pull | input | 1 | Serializer takes the transmit word |
| tx_ch | input | 3 | Channel being transmitted |
| tx_word | output | 32 | Transmit holding word |
| mode_cfg | output | 32 | Mode word |
| rx_on | output | 1 | Receiver on level |
| tx_on | output | 1 | Transmitter on level |
| ck_on | output | 1 | Clock generator on level |
| rx_start | output | 1 | Receiver start pulse |
| rx_stop | output | 1 | Receiver stop pulse |
| tx_start | output | 1 | Transmitter start pulse |
| tx_stop | output | 1 | Transmitter stop pulse |
| ck_start | output | 1 | Clock generator start pulse |
| ck_stop | output | 1 | Clock generator stop pulse |
| dp_reset | output | 1 | One-cycle datapath reset |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- a disable request leaves its unit off, and start pulses coincide with the on level and last one cycle;
- a consumed sample drops receive ready, and overrun stays sticky unless cleared;
- an underrun event raises its flag, and software reset clears the flags and the mask;
- write-only and alias reads return zero.

Some behaviour needs the bench's directed scenarios. They cover the exact status words after mixed push, pull, read and alias sequences and the per-channel bit positions. They also cover `irq` following the mask, events that collide with a clear, inputs that are ignored while a unit is off, and a software reset that carries enable bits with it.

// File: rtl/aud_csr_pkg.sv
`timescale 1ns/1ps
package aud_csr_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 6;
    localparam int NUM_CH = 8;
    localparam int CH_W   = $clog2(NUM_CH);

    localparam logic [ADDR_W-1:0] OFF_CMD   = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_MODE  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_SCLR  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_SSET  = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_IEN   = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_IDIS  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_IMASK = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_RHR   = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_THR   = 6'h24;
    localparam logic [ADDR_W-1:0] OFF_VER   = 6'h28;

    // unit index i uses command bit 2*i to enable and 2*i+1 to disable
    localparam int NUM_UNITS = 3;
    localparam int UNIT_RX   = 0;
    localparam int UNIT_CK   = 1;
    localparam int UNIT_TX   = 2;
    localparam int CMD_SRST  = 7;

    localparam int ST_RXON    = 0;
    localparam int ST_RXRDY   = 1;
    localparam int ST_RXOVR   = 2;
    localparam int ST_TXON    = 4;
    localparam int ST_TXRDY   = 5;
    localparam int ST_TXUND   = 6;
    localparam int ST_RXCH_LO = 8;
    localparam int ST_TXCH_LO = 20;

    localparam logic [REG_W-1:0] FLAG_BITS = 32'h0FF0_FF66;
    localparam logic [REG_W-1:0] IRQ_SRC   = 32'h0000_0066;

    typedef enum logic {
        U_OFF = 1'b0,
        U_ON  = 1'b1
    } unit_state_t;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CMD, SEL_MODE, SEL_STAT, SEL_SCLR, SEL_SSET,
        SEL_IEN, SEL_IDIS, SEL_IMASK, SEL_RHR, SEL_THR, SEL_VER
    } reg_sel_t;
endpackage

// File: rtl/aud_unit_fsm.sv
`timescale 1ns/1ps
module aud_unit_fsm
    import aud_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sreset,
    input  logic en_req,
    input  logic dis_req,
    output logic on,
    output logic start,
    output logic stop
);
    unit_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            U_OFF: if (en_req && !dis_req) state_d = U_ON;
            U_ON:  if (dis_req)            state_d = U_OFF;
        endcase
        if (sreset) state_d = U_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= U_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start <= 1'b0;
            stop  <= 1'b0;
        end else begin
            start <= !sreset && (state_q == U_OFF) && (state_d == U_ON);
            stop  <= !sreset && (state_q == U_ON)  && (state_d == U_OFF);
        end
    end

    assign on = (state_q == U_ON);

    a_r3_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dis_req |=> !on);
    a_r2_start_with_level: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> on);
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/aud_bus_dec.sv
`timescale 1ns/1ps
module aud_bus_dec
    import aud_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  mode_q,
    input  logic [REG_W-1:0]  status,
    input  logic [REG_W-1:0]  mask_q,
    input  logic [REG_W-1:0]  rx_hold,
    input  logic [REG_W-1:0]  version,
    output logic              wr_cmd,
    output logic              wr_mode,
    output logic              wr_sclr,
    output logic              wr_sset,
    output logic              wr_ien,
    output logic              wr_idis,
    output logic              wr_thr,
    output logic              rd_rhr,
    output logic [REG_W-1:0]  bus_rdata
);
    reg_sel_t         sel;
    logic [REG_W-1:0] rd_mux;

    always_comb begin
        unique case (bus_addr)
            OFF_CMD:   sel = SEL_CMD;
            OFF_MODE:  sel = SEL_MODE;
            OFF_STAT:  sel = SEL_STAT;
            OFF_SCLR:  sel = SEL_SCLR;
            OFF_SSET:  sel = SEL_SSET;
            OFF_IEN:   sel = SEL_IEN;
            OFF_IDIS:  sel = SEL_IDIS;
            OFF_IMASK: sel = SEL_IMASK;
            OFF_RHR:   sel = SEL_RHR;
            OFF_THR:   sel = SEL_THR;
            OFF_VER:   sel = SEL_VER;
            default:   sel = SEL_NONE;
        endcase
    end

    assign wr_cmd  = bus_wr && (sel == SEL_CMD);
    assign wr_mode = bus_wr && (sel == SEL_MODE);
    assign wr_sclr = bus_wr && (sel == SEL_SCLR);
    assign wr_sset = bus_wr && (sel == SEL_SSET);
    assign wr_ien  = bus_wr && (sel == SEL_IEN);
    assign wr_idis = bus_wr && (sel == SEL_IDIS);
    assign wr_thr  = bus_wr && (sel == SEL_THR);
    assign rd_rhr  = bus_rd && (sel == SEL_RHR);

    always_comb begin
        unique case (sel)
            SEL_MODE:  rd_mux = mode_q;
            SEL_STAT:  rd_mux = status;
            SEL_IMASK: rd_mux = mask_q;
            SEL_RHR:   rd_mux = rx_hold;
            SEL_VER:   rd_mux = version;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    a_r14_write_only_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (sel == SEL_CMD || sel == SEL_THR || sel == SEL_SCLR ||
                    sel == SEL_SSET || sel == SEL_IEN || sel == SEL_IDIS))
        |=> (bus_rdata == '0));
endmodule

// File: rtl/aud_status_core.sv
`timescale 1ns/1ps
module aud_status_core
    import aud_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sreset,
    input  logic             wr_sclr,
    input  logic             wr_sset,
    input  logic             wr_ien,
    input  logic             wr_idis,
    input  logic             wr_thr,
    input  logic             rd_rhr,
    input  logic [REG_W-1:0] wdata,
    input  logic             rx_on,
    input  logic             tx_on,
    input  logic             rx_push,
    input  logic [CH_W-1:0]  rx_ch,
    input  logic [REG_W-1:0] rx_data,
    input  logic             tx_pull,
    input  logic [CH_W-1:0]  tx_ch,
    output logic [REG_W-1:0] status,
    output logic [REG_W-1:0] mask_q,
    output logic [REG_W-1:0] rx_hold,
    output logic [REG_W-1:0] tx_word,
    output logic             irq
);
    logic [REG_W-1:0] flags_q, flags_d, mask_d;
    logic             rx_ev, tx_ev;

    assign rx_ev = rx_push && rx_on;
    assign tx_ev = tx_pull && tx_on;

    always_comb begin
        flags_d = flags_q;
        if (wr_sset) flags_d = flags_d | (wdata & FLAG_BITS);
        if (wr_sclr) flags_d = flags_d & ~(wdata & FLAG_BITS);
        if (rd_rhr)  flags_d[ST_RXRDY] = 1'b0;
        if (wr_thr)  flags_d[ST_TXRDY] = 1'b0;
        if (rx_ev) begin
            if (flags_q[ST_RXRDY] && !rd_rhr) begin
                flags_d[ST_RXOVR] = 1'b1;
                flags_d[ST_RXCH_LO + int'(rx_ch)] = 1'b1;
            end
            flags_d[ST_RXRDY] = 1'b1;
        end
        if (tx_ev) begin
            if (flags_q[ST_TXRDY]) begin
                flags_d[ST_TXUND] = 1'b1;
                flags_d[ST_TXCH_LO + int'(tx_ch)] = 1'b1;
            end
            flags_d[ST_TXRDY] = 1'b1;
        end
        if (sreset) flags_d = '0;
    end

    always_comb begin
        mask_d = mask_q;
        if (wr_ien)  mask_d = mask_d | (wdata & IRQ_SRC);
        if (wr_idis) mask_d = mask_d & ~(wdata & IRQ_SRC);
        if (sreset)  mask_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            mask_q  <= '0;
            rx_hold <= '0;
            tx_word <= '0;
        end else begin
            flags_q <= flags_d;
            mask_q  <= mask_d;
            if (sreset) begin
                rx_hold <= '0;
                tx_word <= '0;
            end else begin
                if (rx_ev)  rx_hold <= rx_data;
                if (wr_thr) tx_word <= wdata;
            end
        end
    end

    always_comb begin
        status = flags_q;
        status[ST_RXON] = rx_on;
        status[ST_TXON] = tx_on;
    end

    assign irq = |(flags_q & mask_q & IRQ_SRC);

    a_r7_read_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rhr && !rx_ev && !sreset && !wr_sset) |=> !status[ST_RXRDY]);
    a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_RXOVR] && !(wr_sclr && wdata[ST_RXOVR]) && !sreset)
        |=> status[ST_RXOVR]);
    a_r10_underrun_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ev && status[ST_TXRDY] && !sreset) |=> status[ST_TXUND]);
    a_r13_sreset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sreset |=> (mask_q == '0 && (status & FLAG_BITS) == '0 && !irq));
endmodule

// File: rtl/aud_port_csr.sv
`timescale 1ns/1ps
module aud_port_csr
    import aud_csr_pkg::*;
#(
    parameter logic [REG_W-1:0] VERSION = 32'h0000_0113
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              rx_push,
    input  logic [CH_W-1:0]   rx_ch,
    input  logic [REG_W-1:0]  rx_data,
    input  logic              tx_pull,
    input  logic [CH_W-1:0]   tx_ch,
    output logic [REG_W-1:0]  tx_word,
    output logic [REG_W-1:0]  mode_cfg,
    output logic              rx_on,
    output logic              tx_on,
    output logic              ck_on,
    output logic              rx_start,
    output logic              rx_stop,
    output logic              tx_start,
    output logic              tx_stop,
    output logic              ck_start,
    output logic              ck_stop,
    output logic              dp_reset,
    output logic              irq
);
    logic wr_cmd, wr_mode, wr_sclr, wr_sset, wr_ien, wr_idis, wr_thr, rd_rhr;
    logic sreset;
    logic [REG_W-1:0] mode_q, status, mask_q, rx_hold;
    logic [NUM_UNITS-1:0] u_on, u_start, u_stop;

    aud_bus_dec u_dec (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .mode_q(mode_q), .status(status), .mask_q(mask_q),
        .rx_hold(rx_hold), .version(VERSION), .wr_cmd(wr_cmd), .wr_mode(wr_mode),
        .wr_sclr(wr_sclr), .wr_sset(wr_sset), .wr_ien(wr_ien), .wr_idis(wr_idis),
        .wr_thr(wr_thr), .rd_rhr(rd_rhr), .bus_rdata(bus_rdata)
    );

    assign sreset = wr_cmd && bus_wdata[CMD_SRST];

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        aud_unit_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .sreset(sreset),
            .en_req(wr_cmd && bus_wdata[2*i]),
            .dis_req(wr_cmd && bus_wdata[2*i+1]),
            .on(u_on[i]), .start(u_start[i]), .stop(u_stop[i])
        );
    end

    assign rx_on    = u_on[UNIT_RX];
    assign tx_on    = u_on[UNIT_TX];
    assign ck_on    = u_on[UNIT_CK];
    assign rx_start = u_start[UNIT_RX];
    assign tx_start = u_start[UNIT_TX];
    assign ck_start = u_start[UNIT_CK];
    assign rx_stop  = u_stop[UNIT_RX];
    assign tx_stop  = u_stop[UNIT_TX];
    assign ck_stop  = u_stop[UNIT_CK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            dp_reset <= 1'b0;
        end else begin
            dp_reset <= sreset;
            if (sreset)       mode_q <= '0;
            else if (wr_mode) mode_q <= bus_wdata;
        end
    end

    assign mode_cfg = mode_q;

    aud_status_core u_stat (
        .clk(clk), .rst_n(rst_n), .sreset(sreset), .wr_sclr(wr_sclr),
        .wr_sset(wr_sset), .wr_ien(wr_ien), .wr_idis(wr_idis), .wr_thr(wr_thr),
        .rd_rhr(rd_rhr), .wdata(bus_wdata), .rx_on(rx_on), .tx_on(tx_on),
        .rx_push(rx_push), .rx_ch(rx_ch), .rx_data(rx_data), .tx_pull(tx_pull),
        .tx_ch(tx_ch), .status(status), .mask_q(mask_q), .rx_hold(rx_hold),
        .tx_word(tx_word), .irq(irq)
    );

    a_r13_reset_units_off: assert property (@(posedge clk) disable iff (!rst_n)
        dp_reset |-> (!rx_on && !tx_on && !ck_on && mode_cfg == '0));
endmodule

// File: tb/aud_port_csr_test.sv
`timescale 1ns/1ps
module aud_port_csr_test;
    localparam logic [31:0] VER = 32'h0000_0213;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [5:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        rx_push = 0, tx_pull = 0;
    logic [2:0]  rx_ch = 0, tx_ch = 0;
    logic [31:0] rx_data = 0, tx_word, mode_cfg;
    logic rx_on, tx_on, ck_on, rx_start, rx_stop, tx_start, tx_stop;
    logic ck_start, ck_stop, dp_reset, irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    aud_port_csr #(.VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_push(rx_push), .rx_ch(rx_ch), .rx_data(rx_data), .tx_pull(tx_pull),
        .tx_ch(tx_ch), .tx_word(tx_word), .mode_cfg(mode_cfg), .rx_on(rx_on),
        .tx_on(tx_on), .ck_on(ck_on), .rx_start(rx_start), .rx_stop(rx_stop),
        .tx_start(tx_start), .tx_stop(tx_stop), .ck_start(ck_start),
        .ck_stop(ck_stop), .dp_reset(dp_reset), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, $sformatf("read 0x%02h", a), v, exp);
    endtask

    task automatic push(input logic [2:0] ch, input logic [31:0] d);
        rx_push = 1; rx_ch = ch; rx_data = d;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic pull(input logic [2:0] ch);
        tx_pull = 1; tx_ch = ch;
        @(negedge clk);
        tx_pull = 0;
    endtask

    task automatic t_reset;
        check("R1", "irq", {31'b0, irq}, 0);
        check("R1", "levels", {29'b0, rx_on, tx_on, ck_on}, 0);
        rd_chk("R1", 6'h08, 0);
        rd_chk("R1", 6'h04, 0);
        rd_chk("R1", 6'h1C, 0);
        rd_chk("R1", 6'h28, VER);
    endtask

    task automatic t_commands;
        wr(6'h00, 32'h01);
        check("R2", "rx_start pulse", {31'b0, rx_start}, 1);
        check("R2", "rx_on", {31'b0, rx_on}, 1);
        @(negedge clk);
        check("R2", "rx_start one cycle", {31'b0, rx_start}, 0);
        wr(6'h00, 32'h01);
        check("R2", "no pulse when on", {31'b0, rx_start}, 0);
        rd_chk("R2", 6'h08, 32'h01);
        wr(6'h00, 32'h10);
        check("R2", "tx_start", {31'b0, tx_start}, 1);
        rd_chk("R2", 6'h08, 32'h11);
        wr(6'h00, 32'h04);
        check("R2", "ck start/on", {30'b0, ck_start, ck_on}, 2'b11);
        wr(6'h00, 32'h08);
        check("R2", "ck stop/on", {30'b0, ck_stop, ck_on}, 2'b10);
    endtask

    task automatic t_disable_wins;
        wr(6'h00, 32'h0C);
        check("R3", "ck start/on", {30'b0, ck_start, ck_on}, 0);
        wr(6'h00, 32'h03);
        check("R3", "rx stop/on", {30'b0, rx_stop, rx_on}, 2'b10);
        wr(6'h00, 32'h01);
        check("R3", "rx re-enabled", {31'b0, rx_on}, 1);
    endtask

    task automatic t_mode;
        wr(6'h04, 32'hA5A5_1234);
        check("R4", "mode_cfg", mode_cfg, 32'hA5A5_1234);
        rd_chk("R4", 6'h04, 32'hA5A5_1234);
    endtask

    task automatic t_rx;
        push(3'd2, 32'h1111_0001);
        rd_chk("R7", 6'h08, 32'h13);
        rd_chk("R7", 6'h20, 32'h1111_0001);
        rd_chk("R7", 6'h08, 32'h11);
        push(3'd5, 32'h2222_0002);
        push(3'd5, 32'h3333_0003);
        rd_chk("R8", 6'h08, 32'h0000_2017);
        rd_chk("R8", 6'h20, 32'h3333_0003);
        rd_chk("R8", 6'h08, 32'h0000_2015);
    endtask

    task automatic t_irq;
        check("R6", "irq masked", {31'b0, irq}, 0);
        wr(6'h14, 32'h04);
        rd_chk("R6", 6'h1C, 32'h04);
        check("R6", "irq on overrun", {31'b0, irq}, 1);
        wr(6'h14, 32'hFFFF_FFFF);
        rd_chk("R6", 6'h1C, 32'h66);
        wr(6'h0C, 32'h0000_2004);
        rd_chk("R6", 6'h08, 32'h11);
        check("R6", "irq after clear", {31'b0, irq}, 0);
        wr(6'h18, 32'hFFFF_FFFF);
        rd_chk("R6", 6'h1C, 0);
    endtask

    task automatic t_alias;
        wr(6'h10, 32'hFFFF_FFFF);
        rd_chk("R5", 6'h08, 32'h0FF0_FF77);
        wr(6'h0C, 32'hFFFF_FFFF);
        rd_chk("R5", 6'h08, 32'h11);
        wr(6'h10, 32'h40);
        rd_chk("R5", 6'h08, 32'h51);
        wr(6'h0C, 32'h40);
        rd_chk("R5", 6'h08, 32'h11);
    endtask

    task automatic t_tx;
        wr(6'h24, 32'hCAFE_0001);
        check("R9", "tx_word", tx_word, 32'hCAFE_0001);
        pull(3'd3);
        rd_chk("R9", 6'h08, 32'h31);
        pull(3'd6);
        rd_chk("R10", 6'h08, 32'h0400_0071);
        wr(6'h24, 32'hBEEF_0002);
        check("R9", "tx_word reload", tx_word, 32'hBEEF_0002);
        rd_chk("R11", 6'h08, 32'h0400_0051);
    endtask

    task automatic t_sticky;
        push(3'd1, 32'h44);
        rd_chk("R11", 6'h08, 32'h0400_0053);
        bus_wr = 1; bus_addr = 6'h0C; bus_wdata = 32'h0400_0244;
        rx_push = 1; rx_ch = 3'd1; rx_data = 32'h66;
        @(negedge clk);
        bus_wr = 0; rx_push = 0; bus_wdata = 0;
        rd_chk("R11", 6'h08, 32'h0000_0217);
        wr(6'h0C, 32'hFFFF_FFFF);
        rd_chk("R11", 6'h08, 32'h11);
    endtask

    task automatic t_ignore;
        wr(6'h00, 32'h22);
        push(3'd0, 32'h5555);
        pull(3'd0);
        rd_chk("R12", 6'h08, 0);
        rd_chk("R12", 6'h20, 32'h66);
        check("R12", "tx_word kept", tx_word, 32'hBEEF_0002);
    endtask

    task automatic t_sreset;
        wr(6'h00, 32'h11);
        wr(6'h04, 32'h77);
        wr(6'h14, 32'h02);
        wr(6'h10, 32'h02);
        check("R13", "irq before reset", {31'b0, irq}, 1);
        wr(6'h00, 32'h81);
        check("R13", "dp_reset/rx_on/rx_start/tx_stop",
              {28'b0, dp_reset, rx_on, rx_start, tx_stop}, 4'b1000);
        check("R13", "irq", {31'b0, irq}, 0);
        @(negedge clk);
        check("R13", "dp_reset one cycle", {31'b0, dp_reset}, 0);
        check("R13", "tx_word", tx_word, 0);
        rd_chk("R13", 6'h04, 0);
        rd_chk("R13", 6'h1C, 0);
        rd_chk("R13", 6'h08, 0);
        rd_chk("R13", 6'h20, 0);
        rd_chk("R13", 6'h28, VER);
    endtask

    task automatic t_wo_reads;
        wr(6'h04, 32'h1234);
        rd_chk("R14", 6'h00, 0);
        rd_chk("R14", 6'h0C, 0);
        rd_chk("R14", 6'h10, 0);
        rd_chk("R14", 6'h14, 0);
        rd_chk("R14", 6'h18, 0);
        rd_chk("R14", 6'h24, 0);
        rd_chk("R14", 6'h2C, 0);
        rd_chk("R14", 6'h3C, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_commands();
        t_disable_wins();
        t_mode();
        t_rx();
        t_irq();
        t_alias();
        t_tx();
        t_sticky();
        t_ignore();
        t_sreset();
        t_wo_reads();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule